// File: doc/BRIEF.md
# Dual-Core Exclusive Reservation Monitor

This block decides the outcome of every store-exclusive issued by two processor cores that share one memory. Each core has a one-bit local monitor that records only whether a reservation is open or exclusive. It holds no address. A shared global monitor keeps one address tag per core. A load-exclusive arms both the core's local monitor and its tag. A store-exclusive succeeds only when both are still armed and the tag matches the store's word granule. Any store that reaches memory from either core, plain or exclusive, removes every tag on the same word.

For each store-exclusive, the block returns three registered outputs one cycle after the request: a done strobe, a failure flag, and a write-enable that tells the memory whether to commit the data. Task-switch code must issue a clear-exclusive. The local monitor carries no address, so a stale exclusive state left by one task must be removed explicitly before another task runs.

Top module: `excl_access_monitor`

## Requirements
- R1: After a synchronous active-low reset, both local monitors are open and no tag is valid. A store-exclusive issued before any new load-exclusive fails.
- R2: After a load-exclusive, a store-exclusive from the same core to the same word passes if no store has hit that word in between. In the cycle after the request, done is 1, fail is 0 and mem_we is 1.
- R3: Status encoding: fail=0 means success and fail=1 means failure. A failed store-exclusive gives mem_we=0. Done is a one-cycle pulse that occurs only in the cycle after a store-exclusive.
- R4: A store-exclusive to a word other than the reserved one fails.
- R5: Addresses are compared at one 32-bit word: bits [1:0] are ignored, so 0x20 and 0x23 match.
- R6: A plain store from either core, including the reserving core itself, to the reserved word invalidates the reservation, and the next store-exclusive fails.
- R7: A passing store-exclusive from the other core to the reserved word invalidates the reservation.
- R8: A clear-exclusive opens the core's local monitor and drops its tag. A later store-exclusive to the same word fails.
- R9: Every store-exclusive, pass or fail, closes the issuing core's reservation. A second store-exclusive without a new load-exclusive fails.
- R10: If both cores issue a store-exclusive to the same word in the same cycle and both hold valid reservations, core 0 passes and core 1 fails.
- R11: A later load-exclusive replaces the earlier reservation of the same core. A store-exclusive to the older word fails and one to the newer word passes.
- R12: A plain store to a different word leaves an existing reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| c0_ld_ex | input | 1 | Core 0 load-exclusive |
| c0_st_ex | input | 1 | Core 0 store-exclusive |
| c0_st | input | 1 | Core 0 plain store |
| c0_clr_ex | input | 1 | Core 0 clear-exclusive |
| c0_addr | input | ADDR_W | Core 0 byte address |
| c1_ld_ex | input | 1 | Core 1 load-exclusive |
| c1_st_ex | input | 1 | Core 1 store-exclusive |
| c1_st | input | 1 | Core 1 plain store |
| c1_clr_ex | input | 1 | Core 1 clear-exclusive |
| c1_addr | input | ADDR_W | Core 1 byte address |
| c0_mem_we | output | 1 | Core 0 store-exclusive may write memory |
| c0_sx_done | output | 1 | Core 0 store-exclusive status valid |
| c0_sx_fail | output | 1 | Core 0 status: 1 = failed |
| c1_mem_we | output | 1 | Core 1 store-exclusive may write memory |
| c1_sx_done | output | 1 | Core 1 store-exclusive status valid |
| c1_sx_fail | output | 1 | Core 1 status: 1 = failed |

## Verification
All internal state can be seen at the ports only through a later store-exclusive. A stuck or wrongly armed local bit or tag therefore goes unnoticed until the next store-exclusive from that core. One cycle after that store, it shows up as a wrong fail flag and a matching wrong mem_we. The stimulus always places a store-exclusive directly after each event that should change a reservation: load, clear, plain store, foreign exclusive store and reset. The rows include same-word and near-word address pairs, so an off-by-one granule compare or a lost invalidation appears on the very next status pulse.

// File: rtl/excl_mon_pkg.sv
// Shared constants and types for the dual-core exclusive monitor.
// Assumes exactly two cores; the tie rule in excl_resolve depends on it.
package excl_mon_pkg;
    localparam int NUM_CORES = 2;
    typedef logic [NUM_CORES-1:0] core_vec_t;
endpackage

// File: rtl/excl_local_mon.sv
// One-bit local exclusive monitor of a single core: open or exclusive.
// Records no address. Closing has priority over arming in the same cycle.
module excl_local_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic open_i,
    output logic excl_o
);
    // State register: open after reset, armed by a load-exclusive.
    always_ff @(posedge clk) begin
        if (!rst_n)      excl_o <= 1'b0;
        else if (open_i) excl_o <= 1'b0;
        else if (arm_i)  excl_o <= 1'b1;
    end

    AST_OPEN_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |=> !excl_o); // R8
endmodule

// File: rtl/excl_tag_file.sv
// Global monitor: one word-granule tag per core with a valid bit.
// A tag drops on its own core's clear or store-exclusive, or when any
// core writes memory at the tagged granule. Assumes the write strobes
// carry only stores that really reach memory.
module excl_tag_file
    import excl_mon_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  core_vec_t                       arm_i,
    input  core_vec_t                       drop_i,
    input  core_vec_t                       wr_i,
    input  logic [NUM_CORES-1:0][TAG_W-1:0] gran_i,
    output core_vec_t                       vld_o,
    output logic [NUM_CORES-1:0][TAG_W-1:0] tag_o
);
    for (genvar j = 0; j < NUM_CORES; j++) begin : g_tag
        logic hit;

        // Snoop: does any core write memory at this tag's granule?
        always_comb begin
            hit = 1'b0;
            for (int k = 0; k < NUM_CORES; k++)
                if (wr_i[k] && gran_i[k] == tag_o[j]) hit = 1'b1;
        end

        // Tag update: drop, then arm, then snoop invalidation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_o[j] <= 1'b0;
                tag_o[j] <= '0;
            end else if (drop_i[j]) begin
                vld_o[j] <= 1'b0;
            end else if (arm_i[j]) begin
                vld_o[j] <= 1'b1;
                tag_o[j] <= gran_i[j];
            end else if (hit) begin
                vld_o[j] <= 1'b0;
            end
        end

        AST_DROP_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
            drop_i[j] |=> !vld_o[j]); // R9
    end

    AST_RESET_NO_TAGS: assert property (@(posedge clk)
        !rst_n |=> (vld_o == '0)); // R1
endmodule

// File: rtl/excl_resolve.sv
// Decides pass or fail for each store-exclusive and registers the status.
// A core is eligible when its local monitor is exclusive, its tag is valid
// and matches the request granule, and no clear arrives in the same cycle.
// Same-cycle order: core 0's stores come before core 1's.
module excl_resolve
    import excl_mon_pkg::*;
#(
    parameter int TAG_W = 30
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  core_vec_t                       sx_i,
    input  core_vec_t                       st_i,
    input  core_vec_t                       clr_i,
    input  core_vec_t                       local_i,
    input  core_vec_t                       vld_i,
    input  logic [NUM_CORES-1:0][TAG_W-1:0] tag_i,
    input  logic [NUM_CORES-1:0][TAG_W-1:0] gran_i,
    output core_vec_t                       wr_o,
    output core_vec_t                       done_o,
    output core_vec_t                       fail_o,
    output core_vec_t                       we_o
);
    core_vec_t elig, pass;
    logic      same_gran;

    // Per-core eligibility from the local bit and the global tag.
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_elig
        assign elig[i] = sx_i[i] & ~clr_i[i] & local_i[i] & vld_i[i]
                       & (tag_i[i] == gran_i[i]);
    end

    // Tie rule: a core 0 write to the same granule defeats core 1.
    always_comb begin
        same_gran = (gran_i[0] == gran_i[1]);
        pass[0]   = elig[0];
        pass[1]   = elig[1] & ~((st_i[0] | elig[0]) & same_gran);
    end

    assign wr_o = st_i | pass;

    // Status registers: one-cycle report per store-exclusive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= '0;
            fail_o <= '0;
            we_o   <= '0;
        end else begin
            done_o <= sx_i;
            fail_o <= sx_i & ~pass;
            we_o   <= pass;
        end
    end

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
        AST_STATUS_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            sx_i[i] |=> done_o[i]); // R3
        AST_NO_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !sx_i[i] |=> !done_o[i] && !we_o[i]); // R3
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        (sx_i == 2'b11 && gran_i[0] == gran_i[1]) |=> !(we_o[0] && we_o[1])); // R10
endmodule

// File: rtl/excl_access_monitor.sv
// Top: exclusive-access monitor for two cores sharing one memory.
// Per core, an untagged local monitor; shared, a tag per core.
// A load-exclusive arms both. Clear-exclusive or store-exclusive closes both.
// Status outputs arrive one cycle after the store-exclusive.
// Assumes a core's store-exclusive takes precedence over its own
// load-exclusive in the same cycle.
module excl_access_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_ld_ex,
    input  logic              c0_st_ex,
    input  logic              c0_st,
    input  logic              c0_clr_ex,
    input  logic [ADDR_W-1:0] c0_addr,
    input  logic              c1_ld_ex,
    input  logic              c1_st_ex,
    input  logic              c1_st,
    input  logic              c1_clr_ex,
    input  logic [ADDR_W-1:0] c1_addr,
    output logic              c0_mem_we,
    output logic              c0_sx_done,
    output logic              c0_sx_fail,
    output logic              c1_mem_we,
    output logic              c1_sx_done,
    output logic              c1_sx_fail
);
    localparam int TAG_W = ADDR_W - GRAN_LSB;

    core_vec_t ld, sx, st, clr, arm, drop, local_excl, tag_vld, wr, done, fail, we;
    logic [NUM_CORES-1:0][TAG_W-1:0] gran, tag;

    // Gather per-core port signals into vectors.
    assign ld   = {c1_ld_ex, c0_ld_ex};
    assign sx   = {c1_st_ex, c0_st_ex};
    assign st   = {c1_st, c0_st};
    assign clr  = {c1_clr_ex, c0_clr_ex};
    assign gran = {c1_addr[ADDR_W-1:GRAN_LSB], c0_addr[ADDR_W-1:GRAN_LSB]};
    assign drop = sx | clr;
    assign arm  = ld & ~drop;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        excl_local_mon u_local (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_i  (arm[g]),
            .open_i (drop[g]),
            .excl_o (local_excl[g])
        );

        AST_TAG_NEEDS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
            tag_vld[g] |-> local_excl[g]); // R2
    end

    excl_tag_file #(.TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm),
        .drop_i (drop),
        .wr_i   (wr),
        .gran_i (gran),
        .vld_o  (tag_vld),
        .tag_o  (tag)
    );

    excl_resolve #(.TAG_W(TAG_W)) u_resolve (
        .clk     (clk),
        .rst_n   (rst_n),
        .sx_i    (sx),
        .st_i    (st),
        .clr_i   (clr),
        .local_i (local_excl),
        .vld_i   (tag_vld),
        .tag_i   (tag),
        .gran_i  (gran),
        .wr_o    (wr),
        .done_o  (done),
        .fail_o  (fail),
        .we_o    (we)
    );

    assign c0_mem_we  = we[0];
    assign c0_sx_done = done[0];
    assign c0_sx_fail = fail[0];
    assign c1_mem_we  = we[1];
    assign c1_sx_done = done[1];
    assign c1_sx_fail = fail[1];
endmodule

// File: tb/excl_access_monitor_test.sv
// Bench: a vector table walked in order, then directed reset and pulse tests.
// Op code per core: 1 = load-ex, 2 = store-ex, 4 = plain store, 8 = clear-ex.
// Expected status per core: {done, fail, mem_we}.
module excl_access_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c0_ld_ex = 0, c0_st_ex = 0, c0_st = 0, c0_clr_ex = 0;
    logic        c1_ld_ex = 0, c1_st_ex = 0, c1_st = 0, c1_clr_ex = 0;
    logic [31:0] c0_addr = '0, c1_addr = '0;
    logic        c0_mem_we, c0_sx_done, c0_sx_fail, c1_mem_we, c1_sx_done, c1_sx_fail;
    int          n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    excl_access_monitor uut (.*);

    localparam int NV = 31;
    localparam logic [45:0] VEC [NV] = '{
        {4'h2,16'h0010, 4'h0,16'h0000, 3'b110,3'b000}, // R1 no reservation yet
        {4'h1,16'h0010, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h0010, 4'h0,16'h0000, 3'b101,3'b000}, // R2 pass
        {4'h2,16'h0010, 4'h0,16'h0000, 3'b110,3'b000}, // R9 closed
        {4'h1,16'h0010, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h0014, 4'h0,16'h0000, 3'b110,3'b000}, // R4 other word
        {4'h1,16'h0020, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h0023, 4'h0,16'h0000, 3'b101,3'b000}, // R5 same word
        {4'h1,16'h0030, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h0,16'h0000, 4'h4,16'h0031, 3'b000,3'b000},
        {4'h2,16'h0030, 4'h0,16'h0000, 3'b110,3'b000}, // R6 foreign store
        {4'h1,16'h0040, 4'h1,16'h0040, 3'b000,3'b000},
        {4'h0,16'h0000, 4'h2,16'h0040, 3'b000,3'b101}, // R7 core 1 wins
        {4'h2,16'h0040, 4'h0,16'h0000, 3'b110,3'b000}, // R7 core 0 lost
        {4'h1,16'h0050, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h8,16'h0000, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h0050, 4'h0,16'h0000, 3'b110,3'b000}, // R8 cleared
        {4'h1,16'h0060, 4'h1,16'h0060, 3'b000,3'b000},
        {4'h2,16'h0060, 4'h2,16'h0062, 3'b101,3'b110}, // R10 tie
        {4'h1,16'h0070, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h1,16'h0080, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h0070, 4'h0,16'h0000, 3'b110,3'b000}, // R11 old word
        {4'h1,16'h0070, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h1,16'h0080, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h0080, 4'h0,16'h0000, 3'b101,3'b000}, // R11 new word
        {4'h0,16'h0000, 4'h1,16'h0090, 3'b000,3'b000},
        {4'h4,16'h00A0, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h0,16'h0000, 4'h2,16'h0090, 3'b000,3'b101}, // R12 unrelated store
        {4'h1,16'h00B0, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h4,16'h00B0, 4'h0,16'h0000, 3'b000,3'b000},
        {4'h2,16'h00B0, 4'h0,16'h0000, 3'b110,3'b000}  // R6 own store
    };

    task automatic check(input string req, input int core, input logic [2:0] got,
                         input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s core%0d got {done,fail,we}=%b expected %b", req, core, got, exp);
        end
    endtask

    // Drive one cycle of ops (called just after a negedge), capture after the edge.
    task automatic step(input logic [3:0] op0, input logic [31:0] a0,
                        input logic [3:0] op1, input logic [31:0] a1,
                        output logic [2:0] s0, output logic [2:0] s1);
        {c0_clr_ex, c0_st, c0_st_ex, c0_ld_ex} = op0;
        {c1_clr_ex, c1_st, c1_st_ex, c1_ld_ex} = op1;
        c0_addr = a0;
        c1_addr = a1;
        @(posedge clk);
        #2;
        s0 = {c0_sx_done, c0_sx_fail, c0_mem_we};
        s1 = {c1_sx_done, c1_sx_fail, c1_mem_we};
        @(negedge clk);
        {c0_clr_ex, c0_st, c0_st_ex, c0_ld_ex} = '0;
        {c1_clr_ex, c1_st, c1_st_ex, c1_ld_ex} = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] s0, s1;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        check("R1", 0, {c0_sx_done, c0_sx_fail, c0_mem_we}, 3'b000);
        check("R1", 1, {c1_sx_done, c1_sx_fail, c1_mem_we}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v][45:42], {16'h0, VEC[v][41:26]},
                 VEC[v][25:22], {16'h0, VEC[v][21:6]}, s0, s1);
            check($sformatf("R1-12 row %0d", v), 0, s0, VEC[v][5:3]);
            check($sformatf("row %0d", v), 1, s1, VEC[v][2:0]);
        end

        // R3: done is a single-cycle pulse
        step(4'h1, 32'h200, 4'h0, 32'h0, s0, s1);
        step(4'h2, 32'h200, 4'h0, 32'h0, s0, s1);
        check("R3 pass status", 0, s0, 3'b101);
        step(4'h0, 32'h0, 4'h0, 32'h0, s0, s1);
        check("R3 pulse ends", 0, s0, 3'b000);

        // R1: reset drops live reservations of both cores
        step(4'h1, 32'h300, 4'h1, 32'h300, s0, s1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(4'h2, 32'h300, 4'h0, 32'h0, s0, s1);
        check("R1 after reset", 0, s0, 3'b110);
        step(4'h0, 32'h0, 4'h2, 32'h300, s0, s1);
        check("R1 after reset", 1, s1, 3'b110);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule